// File: doc/BRIEF.md
# Event-Driven Display Microsequencer

This block sits between a display-timing counter and a 24-bit pixel bus. The timing counter raises three kinds of strobes: new pixel data, new line and end of line. Each strobe has a programmable link entry that gives the start address of a routine in a 16-word template memory, a 2-bit priority and an enable bit. The counter's offset already skips blanking, so the strobes arrive only during the active region.

When the engine is idle and one or more enabled strobes are present, the highest-priority strobe starts its routine. Strobes that lose arbitration are dropped and are not held for later. A routine runs one template word per cycle, in rising address order, and wraps from 15 to 0. It ends after the first word that has its stop flag set. A word either forwards the pixel word present on the input, or drives its own 24-bit constant, such as zero for blank data after the last pixel of a line. The bus has no back-pressure. The output is a valid-only stream: a display cannot stall, so the consumer must accept a word in every cycle that `bus_valid` is high. The pixel input is sampled at the execution edge and has no handshake.

The template memory has a host write port. The link table is written one entry at a time through a small register interface.

Top module: `disp_useq`

## Requirements
- R1: After a synchronous reset, `busy` and `bus_valid` are 0, `bus_data` is 0 and all three link entries are disabled, so no strobe starts a routine until a link entry is written.
- R2: A strobe whose link entry has its enable bit clear has no effect.
- R3: Among enabled strobes present in the same cycle, the one with the numerically largest priority value is serviced. The other strobes are discarded and never start a routine later.
- R4: Priority ties are resolved in a fixed order: new pixel data wins over new line, and new line wins over end of line.
- R5: A strobe sampled at clock edge k, while the engine is idle, executes the word at the start address at edge k+1 and the following words at k+2, k+3 and so on. The routine ends at the first word with the stop flag set. `busy` is 1 from edge k up to that stop word, and `bus_valid` is 1 after every execution edge.
- R6: A word with opcode 0 (pixel forward) places on `bus_data` the value `pix_in` had at its execution edge.
- R7: A word with opcode 1 (constant) places its 24-bit operand on `bus_data`.
- R8: Strobes sampled while `busy` is 1 are ignored, including on the edge that executes the stop word. A strobe is accepted again on the first edge at which `busy` is 0.
- R9: While the engine is idle, `bus_valid` is 0 and `bus_data` keeps the last value that was driven.
- R10: The program counter wraps from address 15 to address 0 inside a routine.
- R11: A link-table write with selector 3 changes no entry. The valid selectors are 0 for new pixel data, 1 for new line and 2 for end of line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_nd | input | 1 | New-pixel-data strobe |
| evt_nl | input | 1 | New-line strobe |
| evt_eol | input | 1 | End-of-line strobe |
| pix_in | input | 24 | Current pixel word |
| tw_en | input | 1 | Template write strobe |
| tw_addr | input | 4 | Template write address |
| tw_op | input | 1 | Opcode: 0 pixel forward, 1 constant |
| tw_operand | input | 24 | Constant operand |
| tw_stop | input | 1 | Stop flag |
| lw_en | input | 1 | Link write strobe |
| lw_sel | input | 2 | Link entry selector (0 nd, 1 nl, 2 eol) |
| lw_addr | input | 4 | Routine start address |
| lw_prio | input | 2 | Priority, larger wins |
| lw_enable | input | 1 | Link enable bit |
| bus_data | output | 24 | Display data bus |
| bus_valid | output | 1 | Bus carries a new word this cycle |
| busy | output | 1 | A routine is running |

## Verification
The hardest case to reach is a strobe that arrives on the exact edge where the stop word executes. The engine is still busy on that edge, so the strobe must be dropped, and it must not appear as a late restart. The bench runs a three-word routine that crosses the wrap from 15 to 0. It holds an enabled new-line strobe high through every execution edge, including the stop edge, and releases it only after that edge. It then checks that the bus goes quiet and holds its value. Arbitration is swept over all 64 priority assignments against every non-empty set of strobes, and over every enable mask. Each link points at a routine with a distinct constant, so the winner can be read from the bus.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic {
    OP_PIX   = 1'b0,
    OP_CONST = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

  localparam int unsigned EVT_ND  = 0;
  localparam int unsigned EVT_NL  = 1;
  localparam int unsigned EVT_EOL = 2;
  localparam int unsigned NUM_EVT = 3;
endpackage

// File: rtl/dseq_link_arb.sv
module dseq_link_arb #(
  parameter int ADDR_W = 4,
  parameter int PRIO_W = 2,
  parameter int NEVT   = 3,
  localparam int SEL_W = (NEVT > 1) ? $clog2(NEVT + 1) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lw_en,
  input  logic [SEL_W-1:0]  lw_sel,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [PRIO_W-1:0] lw_prio,
  input  logic              lw_enable,
  input  logic [NEVT-1:0]   evt,
  output logic [NEVT-1:0]   grant,
  output logic              go,
  output logic [ADDR_W-1:0] start_addr
);
  logic [NEVT-1:0]   ent_en;
  logic [ADDR_W-1:0] ent_addr [NEVT];
  logic [PRIO_W-1:0] ent_prio [NEVT];

  for (genvar g = 0; g < NEVT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_en[g] <= 1'b0;
      end else if (lw_en && (lw_sel == SEL_W'(g))) begin
        ent_en[g] <= lw_enable;
      end
    end

    always_ff @(posedge clk) begin
      if (lw_en && (lw_sel == SEL_W'(g))) begin
        ent_addr[g] <= lw_addr;
        ent_prio[g] <= lw_prio;
      end
    end
  end

  // Lower index wins ties because a later entry must be strictly larger.
  always_comb begin
    logic              found;
    logic [PRIO_W-1:0] best_p;
    grant      = '0;
    found      = 1'b0;
    best_p     = '0;
    start_addr = '0;
    for (int i = 0; i < NEVT; i++) begin
      if (evt[i] && ent_en[i] && (!found || (ent_prio[i] > best_p))) begin
        found      = 1'b1;
        best_p     = ent_prio[i];
        grant      = '0;
        grant[i]   = 1'b1;
        start_addr = ent_addr[i];
      end
    end
    go = found;
  end
endmodule

// File: rtl/dseq_tmpl_mem.sv
module dseq_tmpl_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 24,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_op,
  input  logic [DATA_W-1:0] wr_operand,
  input  logic              wr_stop,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_op,
  output logic [DATA_W-1:0] rd_operand,
  output logic              rd_stop
);
  logic              m_op      [DEPTH];
  logic              m_stop    [DEPTH];
  logic [DATA_W-1:0] m_operand [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      m_op[wr_addr]      <= wr_op;
      m_stop[wr_addr]    <= wr_stop;
      m_operand[wr_addr] <= wr_operand;
    end
  end

  assign rd_op      = m_op[rd_addr];
  assign rd_stop    = m_stop[rd_addr];
  assign rd_operand = m_operand[rd_addr];
endmodule

// File: rtl/dseq_engine.sv
module dseq_engine
  import dseq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              w_op,
  input  logic [DATA_W-1:0] w_operand,
  input  logic              w_stop,
  input  logic [DATA_W-1:0] pix_in,
  output logic [ADDR_W-1:0] pc,
  output logic              busy,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid
);
  st_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pc        <= '0;
      bus_data  <= '0;
      bus_valid <= 1'b0;
    end else begin
      bus_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            pc    <= start_addr;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          bus_valid <= 1'b1;
          bus_data  <= (op_e'(w_op) == OP_CONST) ? w_operand : pix_in;
          if (w_stop) begin
            state <= ST_IDLE;
          end else begin
            pc <= pc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/disp_useq.sv
module disp_useq
  import dseq_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 4,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_nd,
  input  logic              evt_nl,
  input  logic              evt_eol,
  input  logic [DATA_W-1:0] pix_in,
  input  logic              tw_en,
  input  logic [ADDR_W-1:0] tw_addr,
  input  logic              tw_op,
  input  logic [DATA_W-1:0] tw_operand,
  input  logic              tw_stop,
  input  logic              lw_en,
  input  logic [1:0]        lw_sel,
  input  logic [ADDR_W-1:0] lw_addr,
  input  logic [PRIO_W-1:0] lw_prio,
  input  logic              lw_enable,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid,
  output logic              busy
);
  localparam int NEVT = NUM_EVT;

  logic [NEVT-1:0]   evt_vec;
  logic [NEVT-1:0]   arb_grant;
  logic              arb_go;
  logic [ADDR_W-1:0] arb_start;
  logic [ADDR_W-1:0] pc;
  logic              w_op;
  logic              w_stop;
  logic [DATA_W-1:0] w_operand;

  always_comb begin
    evt_vec          = '0;
    evt_vec[EVT_ND]  = evt_nd;
    evt_vec[EVT_NL]  = evt_nl;
    evt_vec[EVT_EOL] = evt_eol;
  end

  dseq_link_arb #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W), .NEVT(NEVT)) u_arb (
    .clk(clk), .rst(rst),
    .lw_en(lw_en), .lw_sel(lw_sel), .lw_addr(lw_addr),
    .lw_prio(lw_prio), .lw_enable(lw_enable),
    .evt(evt_vec), .grant(arb_grant), .go(arb_go), .start_addr(arb_start)
  );

  dseq_tmpl_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .wr_en(tw_en), .wr_addr(tw_addr), .wr_op(tw_op),
    .wr_operand(tw_operand), .wr_stop(tw_stop),
    .rd_addr(pc), .rd_op(w_op), .rd_operand(w_operand), .rd_stop(w_stop)
  );

  dseq_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst),
    .go(arb_go), .start_addr(arb_start),
    .w_op(w_op), .w_operand(w_operand), .w_stop(w_stop),
    .pix_in(pix_in), .pc(pc), .busy(busy),
    .bus_data(bus_data), .bus_valid(bus_valid)
  );
endmodule

// File: rtl/disp_useq_chk.sv
module disp_useq_chk #(
  parameter int DATA_W = 24,
  parameter int NEVT   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              bus_valid,
  input logic [DATA_W-1:0] bus_data,
  input logic [NEVT-1:0]   grant
);
  // R5: every busy cycle is followed by an executed word
  assert_busy_executes_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> bus_valid);

  // R5: leaving busy happens only on a stop-word execution
  assert_stop_ends_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bus_valid);

  // R9: an idle cycle leaves the bus untouched
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(bus_data) && !bus_valid));

  // R3: at most one strobe wins arbitration
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R8: a word appears only when a routine was already running
  assert_valid_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> $past(busy));
endmodule

bind disp_useq disp_useq_chk #(.DATA_W(DATA_W), .NEVT(NEVT)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .bus_valid(bus_valid),
  .bus_data(bus_data), .grant(arb_grant)
);

// File: tb/sim_disp_useq.sv
module sim_disp_useq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_nd = 0, evt_nl = 0, evt_eol = 0;
  logic [23:0] pix_in = '0;
  logic        tw_en = 0, tw_op = 0, tw_stop = 0;
  logic [3:0]  tw_addr = '0;
  logic [23:0] tw_operand = '0;
  logic        lw_en = 0, lw_enable = 0;
  logic [1:0]  lw_sel = '0, lw_prio = '0;
  logic [3:0]  lw_addr = '0;
  logic [23:0] bus_data;
  logic        bus_valid, busy;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  disp_useq u0 (
    .clk(clk), .rst(rst), .evt_nd(evt_nd), .evt_nl(evt_nl), .evt_eol(evt_eol),
    .pix_in(pix_in), .tw_en(tw_en), .tw_addr(tw_addr), .tw_op(tw_op),
    .tw_operand(tw_operand), .tw_stop(tw_stop), .lw_en(lw_en), .lw_sel(lw_sel),
    .lw_addr(lw_addr), .lw_prio(lw_prio), .lw_enable(lw_enable),
    .bus_data(bus_data), .bus_valid(bus_valid), .busy(busy)
  );

  localparam logic [23:0] K_ND = 24'h111111, K_NL = 24'h222222, K_EOL = 24'h333333;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic twrite(input logic [3:0] a, input logic op, input logic [23:0] k, input logic st);
    tw_en = 1; tw_addr = a; tw_op = op; tw_operand = k; tw_stop = st;
    step();
    tw_en = 0;
  endtask

  task automatic lwrite(input logic [1:0] s, input logic [3:0] a, input logic [1:0] p, input logic e);
    lw_en = 1; lw_sel = s; lw_addr = a; lw_prio = p; lw_enable = e;
    step();
    lw_en = 0;
  endtask

  // Fire a set of strobes (bit0 nd, bit1 nl, bit2 eol) and check a one-word routine.
  task automatic fire_one(input int set, input int win, input string req);
    logic [23:0] exp_k;
    evt_nd = set[0]; evt_nl = set[1]; evt_eol = set[2];
    step();
    evt_nd = 0; evt_nl = 0; evt_eol = 0;
    check(req, {31'd0, busy}, {31'd0, win >= 0});
    step();
    exp_k = (win == 0) ? K_ND : (win == 1) ? K_NL : K_EOL;
    check(req, {31'd0, bus_valid}, {31'd0, win >= 0});
    if (win >= 0) check(req, {8'd0, bus_data}, {8'd0, exp_k});
    check(req, {31'd0, busy}, 32'd0);
    step();
  endtask

  function automatic int winner(input int set, input int en, input int p0, input int p1, input int p2);
    int w = -1;
    int bp = -1;
    int pr [3];
    pr[0] = p0; pr[1] = p1; pr[2] = p2;
    for (int i = 0; i < 3; i++) begin
      if (set[i] && en[i] && pr[i] > bp) begin
        w = i; bp = pr[i];
      end
    end
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) step();
    rst = 0;
    // R1: reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 valid", {31'd0, bus_valid}, 32'd0);
    check("R1 data", {8'd0, bus_data}, 32'd0);
    twrite(4'd0, 1'b1, K_ND, 1'b1);
    twrite(4'd5, 1'b1, K_NL, 1'b1);
    twrite(4'd10, 1'b1, K_EOL, 1'b1);
    fire_one(7, -1, "R1 links disabled");

    // R3 R4: all priority assignments against every strobe set
    for (int p = 0; p < 64; p++) begin
      lwrite(2'd0, 4'd0, p[1:0], 1'b1);
      lwrite(2'd1, 4'd5, p[3:2], 1'b1);
      lwrite(2'd2, 4'd10, p[5:4], 1'b1);
      for (int s = 1; s < 8; s++)
        fire_one(s, winner(s, 7, p & 3, (p >> 2) & 3, (p >> 4) & 3), "R3/R4 arbitration");
    end

    // R2: every enable mask
    for (int m = 0; m < 8; m++) begin
      lwrite(2'd0, 4'd0, 2'd1, m[0]);
      lwrite(2'd1, 4'd5, 2'd1, m[1]);
      lwrite(2'd2, 4'd10, 2'd1, m[2]);
      for (int s = 1; s < 8; s++)
        fire_one(s, winner(s, m, 1, 1, 1), "R2 enable mask");
    end

    // R11: selector 3 writes nothing
    lwrite(2'd0, 4'd0, 2'd0, 1'b1);
    lwrite(2'd1, 4'd5, 2'd0, 1'b1);
    lwrite(2'd2, 4'd10, 2'd0, 1'b1);
    lwrite(2'd3, 4'd5, 2'd3, 1'b0);
    fire_one(4, 2, "R11 eol entry intact");
    fire_one(1, 0, "R11 nd entry intact");
    fire_one(2, 1, "R11 nl entry intact");

    // R5 R6 R7 R8 R10: routine 14,15,0 with a strobe held through it
    twrite(4'd14, 1'b0, 24'd0, 1'b0);
    twrite(4'd15, 1'b1, 24'hABCDEF, 1'b0);
    twrite(4'd0, 1'b0, 24'd0, 1'b1);
    lwrite(2'd0, 4'd14, 2'd3, 1'b1);
    evt_nd = 1; pix_in = 24'h0000AA;
    step();
    evt_nd = 0; evt_nl = 1; pix_in = 24'h000101;
    check("R5 busy after start", {31'd0, busy}, 32'd1);
    check("R5 no word yet", {31'd0, bus_valid}, 32'd0);
    step();
    check("R6 first pixel", {8'd0, bus_data}, 32'h000101);
    check("R5 valid word1", {31'd0, bus_valid}, 32'd1);
    pix_in = 24'h000202;
    step();
    check("R7 constant", {8'd0, bus_data}, 32'hABCDEF);
    check("R5 valid word2", {31'd0, bus_valid}, 32'd1);
    pix_in = 24'h000303;
    step();
    check("R10 wrapped pixel", {8'd0, bus_data}, 32'h000303);
    check("R5 stop ends", {31'd0, busy}, 32'd0);
    evt_nl = 0;
    held = bus_data;
    for (int i = 0; i < 4; i++) begin
      step();
      pix_in = pix_in + 24'h10;
      check("R8 no late restart", {31'd0, bus_valid}, 32'd0);
      check("R9 bus holds", {8'd0, bus_data}, {8'd0, held});
    end
    // R8: accepted again once idle
    fire_one(2, 1, "R8 accepted when idle");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule